// File: doc/BRIEF.md
# Cache Miss Request Serializer

The block is the control core of a first-level data cache in a single-core processor. Eight kinds of request can be pending at once: load miss, store miss, instruction miss, flush, replacement, data invalidate, IO read and IO write. The block takes them one at a time. It picks a winner with a rotating round-robin pointer and records the winner's address, thread and class. It then decides whether the request can run, given a snoop of the cache ways, and issues it to memory as a read or a write.

A write-class request is retired in the cycle memory accepts it. A read-class request is retired in the cycle its response arrives. A request that cannot run is retired without any memory traffic. The dequeue pulse goes back to the queue that holds the request. Two kinds of request also send a line-update message to the load/store unit. A data invalidate sends one with no privileges. A load or store fill sends one with full privileges, the fill data and a way chosen by a per-set counter. The fill also wakes the thread that asked. An instruction fill forwards the response data to the instruction side.

The memory request port is valid/ready. `mem_req_valid` does not wait for `mem_req_ready`. Once raised, it stays high with a constant address and kind until the cycle in which `mem_req_ready` is high; that cycle is the issue. The response, the update message, the wakeup and the instruction fill are single-cycle pulses and cannot be back-pressured.

Top module: `miss_serializer`

## Requirements
- R1: After reset the controller is idle. All pulse outputs (`req_deq`, `mem_req_valid`, `upd_valid`, `wake_valid`, `ifill_valid`) are low until a request is pending. The FSM only ever occupies its idle, send and wait states.
- R2: Kind indices are load 0, store 1, instruction 2, flush 3, replacement 4, invalidate 5, IO read 6 and IO write 7. When several are pending in idle, the grant goes to the first pending index at or after a pointer, searching upward with wrap-around. The pointer then moves to the granted index plus one, modulo 8, and is 0 after reset.
- R3: Load, store, instruction and IO read issue with `mem_req_write`=0. Flush, replacement, invalidate and IO write issue with `mem_req_write`=1. `mem_req_addr` equals the granted request's address.
- R4: A snoop hit means some way has a nonzero privilege pair and a tag equal to address bits [ADDR_W-1 : OFFSET_W+SET_W]. Load and store can run only on a miss. Flush and invalidate can run only on a hit. Instruction, replacement and the IO kinds always run.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the next cycle keeps `mem_req_valid` high with the same address and kind.
- R6: A runnable write-class request raises its `req_deq` bit in its issue cycle. The controller then returns to idle without waiting for a response.
- R7: A request that cannot run raises its `req_deq` bit in the send cycle, and `mem_req_valid` stays low.
- R8: A read-class request raises its `req_deq` bit in the cycle `mem_rsp_valid` is high.
- R9: One cycle after an invalidate issues, `upd_valid` pulses. It carries the lowest-numbered matching way, the address, `upd_priv`=2'b00, `upd_cmd`=0 (info update) and zero data.
- R10: One cycle after a load or store response, `upd_valid` pulses. It carries `upd_priv`=2'b11 (bit 1 write, bit 0 read), the response data and the address. `upd_cmd` is 1 (replace) when every way has a nonzero privilege pair, otherwise 0.
- R11: The way in a load/store fill is a per-set counter. It is 0 after reset and rises by one, modulo the way count, after each load/store fill of that set.
- R12: `wake_valid` pulses together with every load/store fill update, with `wake_tid` set to the thread captured at grant.
- R13: One cycle after an instruction response, `ifill_valid` pulses with the response data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_KINDS | Pending flag per request kind |
| req_addr | input | NUM_KINDS*ADDR_W | Address per kind, kind k at slice k |
| req_tid | input | NUM_KINDS*TID_W | Thread id per kind |
| req_deq | output | NUM_KINDS | Dequeue pulse per kind |
| snoop_tag | input | NUM_WAYS*TAG_W | Tag of each way in the addressed set |
| snoop_priv | input | NUM_WAYS*2 | Privilege pair of each way |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_write | output | 1 | 1 = write class, 0 = read class |
| mem_rsp_valid | input | 1 | Memory response pulse |
| mem_rsp_data | input | DATA_W | Memory response data |
| upd_valid | output | 1 | Line update pulse to load/store unit |
| upd_way | output | WAY_W | Way to update |
| upd_addr | output | ADDR_W | Line address |
| upd_priv | output | 2 | Granted privileges, bit 1 write, bit 0 read |
| upd_data | output | DATA_W | Fill data |
| upd_cmd | output | 1 | 0 = info update, 1 = replacement |
| wake_valid | output | 1 | Thread wakeup pulse |
| wake_tid | output | TID_W | Thread to wake |
| ifill_valid | output | 1 | Instruction fill pulse |
| ifill_data | output | DATA_W | Instruction fill data |

## Verification
The assertions take several things for granted about the inputs. The snoop tags and privileges must stay constant from grant until the request retires. `mem_rsp_valid` must pulse once, and only while a read is outstanding. A pending `req_valid` bit must stay set, with constant address and thread, until its dequeue pulse, and must fall before the next idle cycle. The stimulus meets these rules in three ways. It changes snoop contents and addresses only between batches, once all requests have retired and the controller is idle. It raises a response only after it has seen a read issue. It clears each valid bit at the falling edge after the matching dequeue. Within a batch, memory readiness and response delay are random. This exercises stalls and back-to-back arbitration without breaking those rules.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam int NUM_KINDS = 8;

  typedef enum logic [2:0] {
    K_LOAD  = 3'd0,
    K_STORE = 3'd1,
    K_INSTR = 3'd2,
    K_FLUSH = 3'd3,
    K_REPL  = 3'd4,
    K_DINV  = 3'd5,
    K_IORD  = 3'd6,
    K_IOWR  = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  localparam logic       CMD_INFO    = 1'b0;
  localparam logic       CMD_REPLACE = 1'b1;
  localparam logic [1:0] PRIV_NONE   = 2'b00;
  localparam logic [1:0] PRIV_FULL   = 2'b11;

  function automatic logic kind_writes(kind_e k);
    return (k == K_FLUSH) || (k == K_REPL) || (k == K_DINV) || (k == K_IOWR);
  endfunction

  function automatic logic kind_snoops(kind_e k);
    return (k == K_LOAD) || (k == K_STORE) || (k == K_FLUSH) || (k == K_DINV);
  endfunction

  function automatic logic kind_fills(kind_e k);
    return (k == K_LOAD) || (k == K_STORE);
  endfunction

endpackage

// File: rtl/msr_rr_arbiter.sv
module msr_rr_arbiter #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic          any,
  output logic [IW-1:0] gnt_idx
);

  logic [IW-1:0] ptr_q;

  always_comb begin
    any     = 1'b0;
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      int c;
      c = (int'(ptr_q) + i) % N;
      if (!any && req[c]) begin
        any     = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (advance) begin
      ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end
  end

endmodule

// File: rtl/msr_snoop.sv
module msr_snoop #(
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 22,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS*TAG_W-1:0] snoop_tag,
  input  logic [NUM_WAYS*2-1:0]     snoop_priv,
  input  logic [TAG_W-1:0]          look_tag,
  output logic                      hit,
  output logic                      full,
  output logic [WAY_W-1:0]          hit_way
);

  logic [NUM_WAYS-1:0] busy;
  logic [NUM_WAYS-1:0] match;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign busy[w]  = |snoop_priv[2*w +: 2];
    assign match[w] = busy[w] && (snoop_tag[w*TAG_W +: TAG_W] == look_tag);
  end

  assign hit  = |match;
  assign full = &busy;

  // lowest-numbered matching way wins
  always_comb begin
    hit_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/msr_way_ctr.sv
module msr_way_ctr #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic             bump,
  output logic [WAY_W-1:0] way
);

  logic [WAY_W-1:0] cnt_q [NUM_SETS];

  assign way = cnt_q[set_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) cnt_q[s] <= '0;
    end else if (bump) begin
      cnt_q[set_idx] <= cnt_q[set_idx] + 1'b1;
    end
  end

endmodule

// File: rtl/miss_serializer.sv
module miss_serializer
  import msr_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int TID_W    = 3,
  parameter int DATA_W   = 64,
  localparam int NK      = NUM_KINDS,
  localparam int KIDX_W  = $clog2(NK),
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int TAG_W   = ADDR_W - SET_W - OFFSET_W,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NK-1:0]             req_valid,
  input  logic [NK*ADDR_W-1:0]      req_addr,
  input  logic [NK*TID_W-1:0]       req_tid,
  output logic [NK-1:0]             req_deq,
  input  logic [NUM_WAYS*TAG_W-1:0] snoop_tag,
  input  logic [NUM_WAYS*2-1:0]     snoop_priv,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [ADDR_W-1:0]         mem_req_addr,
  output logic                      mem_req_write,
  input  logic                      mem_rsp_valid,
  input  logic [DATA_W-1:0]         mem_rsp_data,
  output logic                      upd_valid,
  output logic [WAY_W-1:0]          upd_way,
  output logic [ADDR_W-1:0]         upd_addr,
  output logic [1:0]                upd_priv,
  output logic [DATA_W-1:0]         upd_data,
  output logic                      upd_cmd,
  output logic                      wake_valid,
  output logic [TID_W-1:0]          wake_tid,
  output logic                      ifill_valid,
  output logic [DATA_W-1:0]         ifill_data
);

  state_e state_q, state_d;

  // captured grant
  kind_e             g_kind;
  logic [ADDR_W-1:0] g_addr;
  logic [TID_W-1:0]  g_tid;
  logic              g_write;
  logic              g_snoop;
  logic              g_wake;

  logic              arb_any;
  logic [KIDX_W-1:0] arb_idx;
  logic              arb_take;

  logic              snp_hit;
  logic              snp_full;
  logic [WAY_W-1:0]  snp_way;
  logic [WAY_W-1:0]  fill_way;

  logic              runnable;
  logic              issue;
  logic              rsp_here;
  logic              fill_done;

  assign arb_take = (state_q == ST_IDLE) && arb_any;

  msr_rr_arbiter #(.N(NK)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_valid),
    .advance (arb_take),
    .any     (arb_any),
    .gnt_idx (arb_idx)
  );

  msr_snoop #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_snoop (
    .snoop_tag  (snoop_tag),
    .snoop_priv (snoop_priv),
    .look_tag   (g_addr[ADDR_W-1 -: TAG_W]),
    .hit        (snp_hit),
    .full       (snp_full),
    .hit_way    (snp_way)
  );

  msr_way_ctr #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_idx (g_addr[OFFSET_W +: SET_W]),
    .bump    (fill_done),
    .way     (fill_way)
  );

  // snooping writes need a hit, snooping reads need a miss
  always_comb begin
    if (!g_snoop)     runnable = 1'b1;
    else if (g_write) runnable = snp_hit;
    else              runnable = !snp_hit;
  end

  assign mem_req_valid = (state_q == ST_SEND) && runnable;
  assign mem_req_addr  = g_addr;
  assign mem_req_write = g_write;
  assign issue         = mem_req_valid && mem_req_ready;
  assign rsp_here      = (state_q == ST_WAIT) && mem_rsp_valid;
  assign fill_done     = rsp_here && kind_fills(g_kind);

  always_comb begin
    req_deq = '0;
    unique case (state_q)
      ST_SEND: begin
        if (!runnable)               req_deq[g_kind] = 1'b1;
        else if (issue && g_write)   req_deq[g_kind] = 1'b1;
      end
      ST_WAIT: begin
        if (mem_rsp_valid)           req_deq[g_kind] = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (arb_any) state_d = ST_SEND;
      ST_SEND: begin
        if (!runnable)  state_d = ST_IDLE;
        else if (issue) state_d = g_write ? ST_IDLE : ST_WAIT;
      end
      ST_WAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      g_kind  <= K_LOAD;
      g_addr  <= '0;
      g_tid   <= '0;
      g_write <= 1'b0;
      g_snoop <= 1'b0;
      g_wake  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (arb_take) begin
        g_kind  <= kind_e'(arb_idx);
        g_addr  <= req_addr[arb_idx*ADDR_W +: ADDR_W];
        g_tid   <= req_tid[arb_idx*TID_W +: TID_W];
        g_write <= kind_writes(kind_e'(arb_idx));
        g_snoop <= kind_snoops(kind_e'(arb_idx));
        g_wake  <= kind_fills(kind_e'(arb_idx));
      end
    end
  end

  // registered messages to load/store and instruction side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid   <= 1'b0;
      upd_way     <= '0;
      upd_addr    <= '0;
      upd_priv    <= PRIV_NONE;
      upd_data    <= '0;
      upd_cmd     <= CMD_INFO;
      wake_valid  <= 1'b0;
      wake_tid    <= '0;
      ifill_valid <= 1'b0;
      ifill_data  <= '0;
    end else begin
      upd_valid   <= 1'b0;
      wake_valid  <= 1'b0;
      ifill_valid <= 1'b0;
      if (issue && (g_kind == K_DINV)) begin
        upd_valid <= 1'b1;
        upd_way   <= snp_way;
        upd_addr  <= g_addr;
        upd_priv  <= PRIV_NONE;
        upd_data  <= '0;
        upd_cmd   <= CMD_INFO;
      end
      if (fill_done) begin
        upd_valid  <= 1'b1;
        upd_way    <= fill_way;
        upd_addr   <= g_addr;
        upd_priv   <= PRIV_FULL;
        upd_data   <= mem_rsp_data;
        upd_cmd    <= snp_full ? CMD_REPLACE : CMD_INFO;
        wake_valid <= g_wake;
        wake_tid   <= g_tid;
      end
      if (rsp_here && (g_kind == K_INSTR)) begin
        ifill_valid <= 1'b1;
        ifill_data  <= mem_rsp_data;
      end
    end
  end

endmodule

// File: rtl/msr_checker.sv
module msr_checker
  import msr_pkg::*;
#(
  parameter int NK = 8,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    state_q,
  input logic [NK-1:0] req_deq,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_req_write,
  input logic          mem_rsp_valid,
  input logic          upd_valid,
  input logic [1:0]    upd_priv,
  input logic          upd_cmd,
  input logic          wake_valid,
  input logic          ifill_valid
);

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'b11);

  assert_deq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_deq));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  assert_write_no_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=> !mem_req_valid);

  assert_write_deq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |-> (req_deq != '0));

  assert_read_no_deq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !mem_req_write) |-> (req_deq == '0));

  assert_read_deq_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_deq[K_INSTR] || req_deq[K_IORD]) |-> mem_rsp_valid);

  assert_priv_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ((upd_priv == 2'b00 && upd_cmd == 1'b0) || upd_priv == 2'b11));

  assert_wake_with_fill_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (upd_valid && upd_priv == 2'b11));

  assert_ifill_after_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ifill_valid |-> $past(mem_rsp_valid));

endmodule

bind miss_serializer msr_checker #(.NK(NUM_KINDS), .AW(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .state_q       (state_q),
  .req_deq       (req_deq),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_write (mem_req_write),
  .mem_rsp_valid (mem_rsp_valid),
  .upd_valid     (upd_valid),
  .upd_priv      (upd_priv),
  .upd_cmd       (upd_cmd),
  .wake_valid    (wake_valid),
  .ifill_valid   (ifill_valid)
);

// File: tb/sim_miss_serializer.sv
`timescale 1ns/1ps
module sim_miss_serializer;
  import msr_pkg::*;

  localparam int NW  = 4;
  localparam int NS  = 16;
  localparam int AW  = 32;
  localparam int OW  = 6;
  localparam int TW  = 3;
  localparam int DW  = 64;
  localparam int NK  = 8;
  localparam int SW  = 4;
  localparam int TGW = AW - SW - OW;
  localparam int WW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NK-1:0]      req_valid = '0;
  logic [NK*AW-1:0]   req_addr;
  logic [NK*TW-1:0]   req_tid;
  logic [NK-1:0]      req_deq;
  logic [NW*TGW-1:0]  snoop_tag;
  logic [NW*2-1:0]    snoop_priv;
  logic               mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [AW-1:0]      mem_req_addr;
  logic               mem_rsp_valid = 1'b0;
  logic [DW-1:0]      mem_rsp_data = '0;
  logic               upd_valid, upd_cmd, wake_valid, ifill_valid;
  logic [WW-1:0]      upd_way;
  logic [AW-1:0]      upd_addr;
  logic [1:0]         upd_priv;
  logic [DW-1:0]      upd_data, ifill_data;
  logic [TW-1:0]      wake_tid;

  logic [AW-1:0]  addr_k [NK];
  logic [TW-1:0]  tid_k  [NK];
  logic [TGW-1:0] tag_w  [NW];
  logic [1:0]     priv_w [NW];

  always_comb begin
    for (int k = 0; k < NK; k++) begin
      req_addr[k*AW +: AW] = addr_k[k];
      req_tid[k*TW +: TW]  = tid_k[k];
    end
    for (int w = 0; w < NW; w++) begin
      snoop_tag[w*TGW +: TGW] = tag_w[w];
      snoop_priv[w*2 +: 2]    = priv_w[w];
    end
  end

  miss_serializer u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_tid(req_tid), .req_deq(req_deq),
    .snoop_tag(snoop_tag), .snoop_priv(snoop_priv),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_write(mem_req_write),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .upd_valid(upd_valid), .upd_way(upd_way), .upd_addr(upd_addr), .upd_priv(upd_priv),
    .upd_data(upd_data), .upd_cmd(upd_cmd),
    .wake_valid(wake_valid), .wake_tid(wake_tid),
    .ifill_valid(ifill_valid), .ifill_data(ifill_data)
  );

  int checks = 0;
  int fails  = 0;
  int rr_ptr = 0;
  int ctr [NS];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int match_way(input logic [AW-1:0] a);
    for (int w = 0; w < NW; w++)
      if (priv_w[w] != 2'b00 && tag_w[w] == a[AW-1 -: TGW]) return w;
    return -1;
  endfunction

  function automatic bit all_busy();
    for (int w = 0; w < NW; w++) if (priv_w[w] == 2'b00) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit is_wr(input int k);
    return (k == 3) || (k == 4) || (k == 5) || (k == 7);
  endfunction

  function automatic bit can_run(input int k);
    if (k == 0 || k == 1) return match_way(addr_k[k]) < 0;
    if (k == 3 || k == 5) return match_way(addr_k[k]) >= 0;
    return 1'b1;
  endfunction

  function automatic int rr_pick(input logic [NK-1:0] m, input int p);
    for (int i = 0; i < NK; i++) if (m[(p + i) % NK]) return (p + i) % NK;
    return -1;
  endfunction

  function automatic logic [AW-1:0] mk_addr(input logic [TGW-1:0] t, input int s);
    return {t, SW'(s), OW'($urandom)};
  endfunction

  task automatic clear_snoop();
    for (int w = 0; w < NW; w++) begin tag_w[w] = '0; priv_w[w] = 2'b00; end
  endtask

  // run until all kinds in mask retire and all messages have been seen
  task automatic run_batch(input logic [NK-1:0] mask, input int rdy_pct, input int max_dly);
    logic [NK-1:0] pend;
    int rsp_cnt, guard;
    bit exp_upd, exp_wake, exp_if, stall;
    logic [WW-1:0] e_way; logic [AW-1:0] e_addr, stall_addr; logic [1:0] e_priv;
    logic [DW-1:0] e_data, e_ifd; logic e_cmd; logic [TW-1:0] e_tid;
    logic [AW-1:0] iss_addr; logic iss_wr;
    pend = mask; rsp_cnt = -1; guard = 0;
    exp_upd = 0; exp_wake = 0; exp_if = 0; stall = 0;
    iss_addr = '0; iss_wr = 1'b0;
    e_way = '0; e_addr = '0; e_priv = '0; e_data = '0; e_ifd = '0; e_cmd = 0; e_tid = '0;
    stall_addr = '0;
    while ((pend != 0 || exp_upd || exp_if) && guard < 500) begin
      guard++;
      @(negedge clk);
      req_valid     = pend;
      mem_req_ready = (($urandom % 100) < rdy_pct);
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = {$urandom, $urandom}; rsp_cnt = -1;
      end else begin
        mem_rsp_valid = 1'b0;
        if (rsp_cnt > 0) rsp_cnt--;
      end
      #9;
      // messages expected from the previous cycle
      if (exp_upd) begin
        chk(upd_valid, "R9 R10", "upd_valid", upd_valid, 1);
        chk(upd_way == e_way, "R10 R11", "upd_way", upd_way, e_way);
        chk(upd_addr == e_addr && upd_priv == e_priv && upd_cmd == e_cmd,
            "R9 R10", "addr/priv/cmd", {upd_addr, upd_priv, upd_cmd}, {e_addr, e_priv, e_cmd});
        chk(upd_data == e_data, "R10", "upd_data", upd_data, e_data);
      end else if (upd_valid) chk(0, "R9 R10", "unexpected upd_valid", 1, 0);
      if (exp_wake) chk(wake_valid && wake_tid == e_tid, "R12", "wake", {wake_valid, wake_tid}, {1'b1, e_tid});
      else if (wake_valid) chk(0, "R12", "unexpected wake", 1, 0);
      if (exp_if) chk(ifill_valid && ifill_data == e_ifd, "R13", "ifill", ifill_data, e_ifd);
      else if (ifill_valid) chk(0, "R13", "unexpected ifill", 1, 0);
      exp_upd = 0; exp_wake = 0; exp_if = 0;
      if (stall) chk(mem_req_valid && mem_req_addr == stall_addr, "R5", "held request",
                     {mem_req_valid, mem_req_addr}, {1'b1, stall_addr});
      stall = mem_req_valid && !mem_req_ready;
      stall_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        iss_addr = mem_req_addr; iss_wr = mem_req_write;
        if (!mem_req_write) rsp_cnt = $urandom % (max_dly + 1);
      end
      if (req_deq != 0) begin
        int k, ek, mw;
        k = -1;
        for (int i = 0; i < NK; i++) if (req_deq[i]) k = i;
        ek = rr_pick(pend, rr_ptr);
        chk(k == ek, "R2", "grant order", k, ek);
        if (!can_run(k)) begin
          chk(!(mem_req_valid), "R7 R4", "no issue when blocked", mem_req_valid, 0);
        end else if (is_wr(k)) begin
          chk(mem_req_valid && mem_req_ready, "R6", "deq at issue", {mem_req_valid, mem_req_ready}, 2'b11);
          chk(iss_wr && iss_addr == addr_k[k], "R3", "write issue", {iss_wr, iss_addr}, {1'b1, addr_k[k]});
          if (k == 5) begin
            mw = match_way(addr_k[k]);
            exp_upd = 1; e_way = WW'(mw); e_addr = addr_k[k]; e_priv = 2'b00; e_cmd = 1'b0; e_data = '0;
          end
        end else begin
          chk(mem_rsp_valid, "R8", "deq with response", mem_rsp_valid, 1);
          chk(!iss_wr && iss_addr == addr_k[k], "R3", "read issue", {iss_wr, iss_addr}, {1'b0, addr_k[k]});
          if (k == 0 || k == 1) begin
            int s;
            s = int'(addr_k[k][OW +: SW]);
            exp_upd = 1; exp_wake = 1; e_tid = tid_k[k];
            e_way = WW'(ctr[s]); e_addr = addr_k[k]; e_priv = 2'b11;
            e_cmd = all_busy(); e_data = mem_rsp_data;
            ctr[s] = (ctr[s] + 1) % NW;
          end
          if (k == 2) begin exp_if = 1; e_ifd = mem_rsp_data; end
        end
        if (k >= 0) begin
          pend[k] = 1'b0;
          rr_ptr = (k + 1) % NK;
        end
      end
    end
    if (guard >= 500) chk(0, "R2", "batch did not retire", pend, 0);
    @(negedge clk);
    req_valid = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) ctr[s] = 0;
    for (int k = 0; k < NK; k++) begin addr_k[k] = '0; tid_k[k] = TW'(k); end
    clear_snoop();
    req_valid = '1;
    repeat (4) @(negedge clk);
    req_valid = '0;
    rst_n = 1'b1;
    #9;
    chk(!mem_req_valid && req_deq == 0 && !upd_valid && !wake_valid && !ifill_valid,
        "R1", "quiet after reset", {mem_req_valid, req_deq, upd_valid, wake_valid, ifill_valid}, 0);
    repeat (3) @(negedge clk);
    #9;
    chk(!mem_req_valid && req_deq == 0 && !upd_valid, "R1", "idle without requests",
        {mem_req_valid, req_deq, upd_valid}, 0);

    // R10 load fill into empty set, counter at zero, not full
    addr_k[0] = mk_addr(22'h1111, 3); tid_k[0] = 3'd5;
    run_batch(8'b0000_0001, 100, 0);
    // R11 second fill of the same set with every way busy: replace, way 1
    for (int w = 0; w < NW; w++) begin tag_w[w] = TGW'(w + 100); priv_w[w] = 2'b01; end
    addr_k[1] = mk_addr(22'h2222, 3); tid_k[1] = 3'd2;
    run_batch(8'b0000_0010, 50, 3);
    // R7 load hit: not runnable
    addr_k[0] = mk_addr(TGW'(102), 5);
    run_batch(8'b0000_0001, 100, 0);
    // R9 invalidate hit on way 2
    clear_snoop(); tag_w[2] = 22'h0abc; priv_w[2] = 2'b10; tag_w[3] = 22'h0abc; priv_w[3] = 2'b11;
    addr_k[5] = mk_addr(22'h0abc, 7);
    run_batch(8'b0010_0000, 40, 0);
    // R7 invalidate and flush miss
    addr_k[5] = mk_addr(22'h0fff, 7); addr_k[3] = mk_addr(22'h0eee, 1);
    run_batch(8'b0010_1000, 100, 0);
    // R6 flush hit, replacement, IO write; R8 R13 instruction and IO read
    addr_k[3] = mk_addr(22'h0abc, 2); addr_k[4] = mk_addr(22'h0123, 9);
    addr_k[7] = mk_addr(22'h0321, 4); addr_k[2] = mk_addr(22'h0777, 6);
    addr_k[6] = mk_addr(22'h0555, 0);
    run_batch(8'b1101_1100, 60, 2);
    // R2 all eight pending at once
    addr_k[0] = mk_addr(22'h3000, 2); addr_k[1] = mk_addr(22'h3001, 2);
    addr_k[5] = mk_addr(22'h0abc, 11);
    run_batch(8'hff, 70, 2);

    // constrained random batches
    for (int b = 0; b < 250; b++) begin
      logic [TGW-1:0] pool [3];
      logic [NK-1:0] m;
      pool[0] = 22'h0a0a; pool[1] = 22'h0b0b; pool[2] = TGW'($urandom);
      for (int w = 0; w < NW; w++) begin
        tag_w[w]  = pool[$urandom % 3];
        priv_w[w] = 2'($urandom);
      end
      for (int k = 0; k < NK; k++) begin
        addr_k[k] = mk_addr(pool[$urandom % 3], int'($urandom % 4));
        tid_k[k]  = TW'($urandom);
      end
      m = NK'($urandom);
      if (m == 0) m = 8'h01;
      run_batch(m, 30 + int'($urandom % 71), int'($urandom % 4));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule